// File: doc/BRIEF.md
# Overcurrent Fault Counter Sequencer

This block sits between the analog overcurrent comparator of a synchronous buck controller and its gate drivers. In every switching cycle it waits for the switch node to rise and then masks the comparator for a fixed blanking window. After that window an overcurrent indication cuts the high-side pulse short. Once the soft-start ramp has finished, a saturating 3-bit event counter tallies the cycles: it goes up for each cycle that saw an overcurrent and down for each clean cycle.

When the counter fills, the block declares a fault. It switches both gate drives off and starts a hiccup timeout, using the soft-start capacitor as its timer. The capacitor is drained and recharged several times, and each recharge to its upper threshold takes one count off the counter. When the count reaches zero, the fault clears. The capacitor is drained one last time so that the converter restarts with a complete soft-start. A shutdown input overrides everything.

Top module: `ocp_fault_sequencer`

## Requirements
- R1: `pulse_term_o` stays low while `sw_high_i` is low. After `sw_high_i` rises it also stays low for the first `BLANK_CYC` clock edges at which `sw_high_i` is high. From the following cycle, `oc_cmp_i` high with `sw_high_i` high drives `pulse_term_o` high in the same cycle.
- R2: Once an overcurrent has been qualified, `pulse_term_o` stays high until the clock edge at which `pwm_tick_i` is sampled high. After that edge it is low again, unless a new qualified event occurs.
- R3: When `pwm_tick_i` is sampled high, soft-start is complete and no fault timeout is running, the counter changes by one. It goes up if the ending cycle saw a qualified overcurrent and down if it did not.
- R4: The counter saturates at 0 and at 7 and never wraps. Clean cycles at a count of 0 leave it at 0, so seven consecutive overcurrent cycles are still needed to reach a fault.
- R5: One clock after the count reaches 7, the following outputs go high: `fault_o`, `hs_off_o`, `ls_off_o` and `ss_dischg_o`. At that moment the count drops to 6. `ls_off_o` stays high for the whole timeout.
- R6: During the timeout, `cap_empty_i` ends the discharge (`ss_dischg_o` goes low one clock later). `cap_upper_i` during the following recharge removes one count and starts a new discharge. The sixth such recharge brings the count to 0 and starts a final discharge with both drives still off. `cap_empty_i` then releases both drives.
- R7: While `ss_done_i` is low, qualified overcurrents still assert `pulse_term_o`, but they do not change the counter.
- R8: While `sd_i` is high, `hs_off_o` and `ls_off_o` are high. One clock after `sd_i` is sampled high, `fault_o` is low and the counter is 0.
- R9: `fault_o` is high from the clock after the count reaches 7 until the clock after the recharge that brings the count to 0.
- R10: Switching cycles and overcurrent events during the timeout leave the counter unchanged. After a restart, exactly seven consecutive overcurrent cycles are needed for a new fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_i | input | 1 | Shutdown request from the soft-start pin comparator |
| oc_cmp_i | input | 1 | High-side overcurrent comparator output |
| sw_high_i | input | 1 | Switch node above the qualification level |
| pwm_tick_i | input | 1 | One-clock pulse at each switching cycle boundary |
| ss_done_i | input | 1 | Soft-start ramp complete |
| cap_empty_i | input | 1 | Soft-start capacitor fully discharged |
| cap_upper_i | input | 1 | Soft-start capacitor at its upper timeout threshold |
| pulse_term_o | output | 1 | Terminate the present high-side pulse |
| ss_dischg_o | output | 1 | Enable the soft-start capacitor discharge switch |
| fault_o | output | 1 | Overcurrent fault timeout in progress |
| hs_off_o | output | 1 | Force the high-side drive off |
| ls_off_o | output | 1 | Force the low-side drive off |

## Verification
The assertions assume that the following inputs are synchronous to the clock and held for at least one edge: `pwm_tick_i` as a single-clock pulse, and the capacitor level flags as single-clock pulses. They also assume that `sw_high_i` falls before each cycle boundary. The stimulus keeps to these rules. Each switching cycle is built as a high phase of the switch node longer than the blanking window, an optional one-clock overcurrent, a low phase and then a lone tick. The capacitor flags are pulsed only in the timeout state where they belong. Shutdown is applied only between cycles.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    HC_RUN    = 2'd0,
    HC_DRAIN  = 2'd1,
    HC_CHARGE = 2'd2,
    HC_REARM  = 2'd3
  } hc_state_e;
endpackage

// File: rtl/ocp_event_detect.sv
module ocp_event_detect #(
  parameter int BLANK_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_cmp_i,
  input  logic sw_high_i,
  input  logic tick_i,
  output logic pulse_term_o,
  output logic cyc_oc_o
);
  localparam int BW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);

  logic armed;
  logic oc_valid;
  logic term_q;

  generate
    if (BLANK_CYC == 0) begin : g_noblank
      assign armed = 1'b1;
    end else begin : g_blank
      localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);
      logic [BW-1:0] blank_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                blank_q <= '0;
        else if (!sw_high_i)        blank_q <= '0;
        else if (blank_q != BLANK_END) blank_q <= blank_q + 1'b1;
      end
      assign armed = (blank_q == BLANK_END);

      AST_BLANK_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sw_high_i) |-> !oc_valid); // R1
    end
  endgenerate

  assign oc_valid = sw_high_i & armed & oc_cmp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       term_q <= 1'b0;
    else if (tick_i)   term_q <= 1'b0;
    else if (oc_valid) term_q <= 1'b1;
  end

  assign pulse_term_o = oc_valid | term_q;
  assign cyc_oc_o     = oc_valid | term_q;

  AST_TERM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_q && !tick_i) |=> pulse_term_o); // R2
endmodule

// File: rtl/ocp_sat_counter.sv
module ocp_sat_counter #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] cnt_o,
  output logic         full_o,
  output logic         one_o
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};
  localparam logic [W-1:0] CONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (up_i && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    else if (dn_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CMAX);
  assign one_o  = (cnt_q == CONE);

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> !((cnt_q == '0 && $past(cnt_q) == CMAX) ||
                 (cnt_q == CMAX && $past(cnt_q) == '0))); // R4
endmodule

// File: rtl/ocp_hiccup_fsm.sv
module ocp_hiccup_fsm
  import ocp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sd_i,
  input  logic tick_i,
  input  logic ss_done_i,
  input  logic cyc_oc_i,
  input  logic cap_empty_i,
  input  logic cap_upper_i,
  input  logic cnt_full_i,
  input  logic cnt_one_i,
  output logic up_o,
  output logic dn_o,
  output logic clr_o,
  output logic run_o,
  output logic fault_o,
  output logic ss_dischg_o,
  output logic hs_off_o,
  output logic ls_off_o
);
  hc_state_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_q <= HC_RUN;
    else if (sd_i) st_q <= HC_RUN;
    else           st_q <= st_d;
  end

  always_comb begin
    st_d = st_q;
    up_o = 1'b0;
    dn_o = 1'b0;
    unique case (st_q)
      HC_RUN: begin
        if (cnt_full_i) begin
          dn_o = 1'b1;  // first timeout step taken as the drain starts
          st_d = HC_DRAIN;
        end else if (tick_i && ss_done_i) begin
          up_o = cyc_oc_i;
          dn_o = !cyc_oc_i;
        end
      end
      HC_DRAIN:  if (cap_empty_i) st_d = HC_CHARGE;
      HC_CHARGE: if (cap_upper_i) begin
        dn_o = 1'b1;
        st_d = cnt_one_i ? HC_REARM : HC_DRAIN;
      end
      HC_REARM:  if (cap_empty_i) st_d = HC_RUN;
      default:   st_d = HC_RUN;
    endcase
  end

  assign clr_o       = sd_i;
  assign run_o       = (st_q == HC_RUN);
  assign fault_o     = (st_q == HC_DRAIN) || (st_q == HC_CHARGE);
  assign ss_dischg_o = (st_q == HC_DRAIN) || (st_q == HC_REARM);
  assign hs_off_o    = sd_i || (st_q != HC_RUN);
  assign ls_off_o    = sd_i || (st_q != HC_RUN);

  AST_FAULT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HC_RUN && cnt_full_i && !sd_i) |=> (fault_o && ls_off_o && ss_dischg_o)); // R5
  AST_DRAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HC_DRAIN && cap_empty_i && !sd_i) |=> (!ss_dischg_o && fault_o)); // R6
  AST_SD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_i |=> !fault_o); // R8
endmodule

// File: rtl/ocp_fault_sequencer.sv
module ocp_fault_sequencer #(
  parameter int BLANK_CYC = 25,
  parameter int CNT_W     = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sd_i,
  input  logic oc_cmp_i,
  input  logic sw_high_i,
  input  logic pwm_tick_i,
  input  logic ss_done_i,
  input  logic cap_empty_i,
  input  logic cap_upper_i,
  output logic pulse_term_o,
  output logic ss_dischg_o,
  output logic fault_o,
  output logic hs_off_o,
  output logic ls_off_o
);
  logic             cyc_oc;
  logic             cnt_up, cnt_dn, cnt_clr, cnt_full, cnt_one, in_run;
  logic [CNT_W-1:0] cnt;

  ocp_event_detect #(.BLANK_CYC(BLANK_CYC)) u_evt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .oc_cmp_i     (oc_cmp_i),
    .sw_high_i    (sw_high_i),
    .tick_i       (pwm_tick_i),
    .pulse_term_o (pulse_term_o),
    .cyc_oc_o     (cyc_oc)
  );

  ocp_sat_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .up_i   (cnt_up),
    .dn_i   (cnt_dn),
    .cnt_o  (cnt),
    .full_o (cnt_full),
    .one_o  (cnt_one)
  );

  ocp_hiccup_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sd_i        (sd_i),
    .tick_i      (pwm_tick_i),
    .ss_done_i   (ss_done_i),
    .cyc_oc_i    (cyc_oc),
    .cap_empty_i (cap_empty_i),
    .cap_upper_i (cap_upper_i),
    .cnt_full_i  (cnt_full),
    .cnt_one_i   (cnt_one),
    .up_o        (cnt_up),
    .dn_o        (cnt_dn),
    .clr_o       (cnt_clr),
    .run_o       (in_run),
    .fault_o     (fault_o),
    .ss_dischg_o (ss_dischg_o),
    .hs_off_o    (hs_off_o),
    .ls_off_o    (ls_off_o)
  );

  AST_SS_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni || sd_i)
    (in_run && !cnt_full && !ss_done_i) |=> (cnt == $past(cnt))); // R7
  AST_FAULT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (cnt != '0)); // R9
endmodule

// File: tb/ocp_fault_sequencer_tb_top.sv
`timescale 1ns/1ps
module ocp_fault_sequencer_tb_top;
  localparam int BLANK = 25;

  typedef struct packed {
    logic [31:0] pat;
    int          len;
    int          fault_at;
  } vec_t;

  // bit i of pat = overcurrent in switching cycle i; fault_at = cycle after which fault_o rises
  localparam vec_t VECS [5] = '{
    '{32'h0000_007F,  7,  6},
    '{32'h0000_01BF,  9,  8},
    '{32'h0000_0FE0, 12, 11},
    '{32'h0000_0555, 12, -1},
    '{32'h0001_B6DB, 17, 16}
  };

  logic clk = 1'b0;
  logic rst_n, sd, oc_cmp, sw_high, tick, ss_done, cap_empty, cap_upper;
  logic pulse_term, ss_dischg, fault, hs_off, ls_off;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;

  ocp_fault_sequencer #(.BLANK_CYC(BLANK), .CNT_W(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sd_i(sd), .oc_cmp_i(oc_cmp), .sw_high_i(sw_high),
    .pwm_tick_i(tick), .ss_done_i(ss_done), .cap_empty_i(cap_empty), .cap_upper_i(cap_upper),
    .pulse_term_o(pulse_term), .ss_dischg_o(ss_dischg), .fault_o(fault),
    .hs_off_o(hs_off), .ls_off_o(ls_off)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clk1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_cycle(input bit oc);
    sw_high = 1'b1;
    repeat (BLANK + 2) clk1;
    if (oc) begin
      oc_cmp = 1'b1;
      #1 chk("R2 terminate", pulse_term, 1'b1);
      clk1;
    end
    oc_cmp = 1'b0; sw_high = 1'b0;
    clk1;
    tick = 1'b1;
    clk1;
    tick = 1'b0;
    clk1;
  endtask

  task automatic do_sd;
    sd = 1'b1;
    #1 chk("R8 hs off", hs_off, 1'b1);
    chk("R8 ls off", ls_off, 1'b1);
    clk1;
    chk("R8 fault clr", fault, 1'b0);
    sd = 1'b0;
    clk1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sd = 1'b0; oc_cmp = 1'b0; sw_high = 1'b0; tick = 1'b0;
    ss_done = 1'b0; cap_empty = 1'b0; cap_upper = 1'b0;
    repeat (3) clk1;
    rst_n = 1'b1;
    clk1;
    chk("reset fault", fault, 1'b0);
    chk("reset hs", hs_off, 1'b0);
    chk("reset ls", ls_off, 1'b0);
    chk("reset dischg", ss_dischg, 1'b0);
    chk("reset term", pulse_term, 1'b0);

    // counting patterns: R3, R4, R5
    for (int v = 0; v < 5; v++) begin
      do_sd();
      ss_done = 1'b1;
      for (int i = 0; i < VECS[v].len; i++) begin
        run_cycle(VECS[v].pat[i]);
        chk($sformatf("R3 vec%0d cyc%0d fault", v, i), fault,
            (VECS[v].fault_at >= 0 && i >= VECS[v].fault_at));
      end
      if (VECS[v].fault_at >= 0) begin
        chk("R5 hs off", hs_off, 1'b1);
        chk("R5 ls off", ls_off, 1'b1);
        chk("R5 dischg", ss_dischg, 1'b1);
      end
    end

    // R1 blanking and qualifier
    do_sd();
    oc_cmp = 1'b1; sw_high = 1'b0;
    repeat (3) clk1;
    chk("R1 sw low", pulse_term, 1'b0);
    sw_high = 1'b1;
    for (int j = 1; j <= BLANK + 1; j++) begin
      clk1;
      chk($sformatf("R1 blank edge %0d", j), pulse_term, (j >= BLANK));
    end
    oc_cmp = 1'b0; sw_high = 1'b0;
    clk1;
    chk("R2 held", pulse_term, 1'b1);
    tick = 1'b1; clk1; tick = 1'b0;
    chk("R2 cleared", pulse_term, 1'b0);
    clk1;

    // R7 soft-start: limit active, nothing counted
    do_sd();
    ss_done = 1'b0;
    for (int i = 0; i < 10; i++) run_cycle(1'b1);
    chk("R7 no fault", fault, 1'b0);
    ss_done = 1'b1;
    for (int i = 0; i < 6; i++) run_cycle(1'b1);
    chk("R7 six counted", fault, 1'b0);
    run_cycle(1'b1);
    chk("R7 seventh", fault, 1'b1);

    // R6 / R9 / R10 hiccup timeout
    for (int k = 0; k < 6; k++) begin
      cap_empty = 1'b1; clk1; cap_empty = 1'b0;
      chk("R6 drain off", ss_dischg, 1'b0);
      chk("R9 fault held", fault, 1'b1);
      chk("R5 ls off timeout", ls_off, 1'b1);
      run_cycle(1'b1);
      chk("R10 ignored", fault, 1'b1);
      cap_upper = 1'b1; clk1; cap_upper = 1'b0;
      chk($sformatf("R9 fault after upper %0d", k), fault, (k < 5));
      chk("R6 redrain", ss_dischg, 1'b1);
      chk("R6 hs off", hs_off, 1'b1);
    end
    cap_empty = 1'b1; clk1; cap_empty = 1'b0;
    chk("R6 hs on", hs_off, 1'b0);
    chk("R6 ls on", ls_off, 1'b0);
    chk("R6 dischg off", ss_dischg, 1'b0);
    for (int i = 0; i < 6; i++) run_cycle(1'b1);
    chk("R10 count zero", fault, 1'b0);
    run_cycle(1'b1);
    chk("R10 refault", fault, 1'b1);

    // R8 shutdown clears a partial count
    do_sd();
    for (int i = 0; i < 6; i++) run_cycle(1'b1);
    do_sd();
    for (int i = 0; i < 6; i++) run_cycle(1'b1);
    chk("R8 count cleared", fault, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule